// File: doc/BRIEF.md
# Stack and Control-Flow Sequencer

This block owns the stack pointer and the instruction pointer of a simple 32-bit processor core. It handles one control operation at a time: push, pop, call, return, unconditional jump, and conditional jumps on the zero or sign flag. It also has a plain advance operation that moves the instruction pointer past an instruction that does not touch control flow. The block drives a single-ported, word-wide synchronous memory. Read data comes back in the cycle after the read strobe.

The stack grows toward lower addresses in steps of four bytes, and the stack pointer always names the word on top. A call stores its return address (the instruction pointer plus the call's length) and then redirects. A return takes that word back into the instruction pointer. Pop, call and return each occupy two cycles. During the second cycle `busy` is high and any operation offered is dropped. All other operations finish in one cycle.

Top module: `stack_flow_unit`

## Requirements
- R1: While reset is held and after it is released, the stack pointer equals `ESP_INIT`, the instruction pointer equals `EIP_INIT`, `memWe`, `memRe`, `popValid` and `busy` are low.
- R2: An accepted push (opCode 1) raises `memWe` in its accept cycle with `memAddr` = stack pointer − 4 and `memWdata` = `pushData`. After that edge the stack pointer is 4 lower and the instruction pointer has advanced by `instLen`.
- R3: An accepted pop (opCode 2) raises `memRe` with `memAddr` = stack pointer. After the second edge, `popData` holds the word read, `popValid` is high for one cycle, the stack pointer is 4 higher and the instruction pointer has advanced by `instLen`.
- R4: An accepted call (opCode 3) raises `memWe` with `memAddr` = stack pointer − 4 and `memWdata` = instruction pointer + `instLen`. After the second edge the instruction pointer equals `target` and the stack pointer is 4 lower.
- R5: An accepted return (opCode 4) raises `memRe` with `memAddr` = stack pointer. After the second edge the instruction pointer equals the word read and the stack pointer is 4 higher.
- R6: An accepted jump (opCode 5) loads `target` into the instruction pointer after one edge, with no memory strobe and the stack pointer unchanged.
- R7: A jump-if-zero (opCode 6) loads `target` when `flagZero` is 1 and otherwise advances by `instLen`. A jump-if-negative (opCode 7) does the same using `flagSign`. Neither touches memory.
- R8: An advance (opCode 0) adds `instLen` to the instruction pointer in one cycle, with no memory strobe and the stack pointer unchanged.
- R9: `busy` is high for exactly the second cycle of a pop, call or return. An operation offered while `busy` is high raises no memory strobe and changes no pointer beyond what the running operation does.
- R10: `memWe` and `memRe` are never high together, and the stack pointer only ever changes by exactly 4.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is offered this cycle |
| opCode | input | 3 | Operation selector (0 advance … 7 jump-if-negative) |
| pushData | input | XLEN | Word stored by a push |
| target | input | XLEN | Destination for call and jumps |
| instLen | input | LEN_W | Byte length of the current instruction |
| flagZero | input | 1 | Zero result flag |
| flagSign | input | 1 | Negative result flag |
| memRdata | input | XLEN | Read data, valid the cycle after `memRe` |
| memAddr | output | XLEN | Memory byte address |
| memWdata | output | XLEN | Memory write data |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| popData | output | XLEN | Last popped word |
| popValid | output | 1 | One-cycle pulse when `popData` is updated |
| eip | output | XLEN | Current instruction pointer |
| esp | output | XLEN | Current stack pointer |
| busy | output | 1 | Second cycle of a two-cycle operation |

## Verification
A new operation can arrive in the same cycle as the finishing phase of a call, return or pop, where the redirect or the pop capture is completing. The bench provokes this by keeping `opValid` high with a push through that phase. It then judges that no memory strobe appears in that cycle, that the finishing operation's pointer results match the reference model, and that no trace of the dropped push shows in the stack pointer afterwards. Randomly mixed sequences also place a push's memory write right after a return's redirect, which exercises back-to-back stack-pointer updates.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NEXT = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_JMP  = 3'd5,
    OP_JZ   = 3'd6,
    OP_JS   = 3'd7
  } stkOp_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CALL2 = 2'd1,
    PH_RET2 = 2'd2,
    PH_POP2 = 2'd3
  } stkPhase_e;

  // strobes from the sequencer to the pointer datapath
  typedef struct packed {
    logic latchTgt;    // hold target for the redirect phase
    logic memWe;
    logic memRe;
    logic addrBelow;   // address is stack pointer minus one word
    logic wdataRet;    // write data is the return address
    logic espDown;
    logic espUp;
    logic eipSeq;      // advance by instruction length
    logic eipTgtIn;    // load target input now
    logic eipTgtHeld;  // load held target
    logic eipMem;      // load read data
    logic capPop;      // capture read data as popped word
  } stkStrobe_t;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       flagZero,
  input  logic       flagSign,
  output stkStrobe_t strobe,
  output logic       busy
);

  stkPhase_e phase, phaseNext;
  logic      accept;
  stkOp_e    opSel;

  assign opSel  = stkOp_e'(opCode);
  assign accept = rstN && opValid && (phase == PH_IDLE);
  assign busy   = (phase != PH_IDLE);

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (accept) begin
          unique case (opSel)
            OP_NEXT: strobe.eipSeq = 1'b1;
            OP_PUSH: begin
              strobe.memWe     = 1'b1;
              strobe.addrBelow = 1'b1;
              strobe.espDown   = 1'b1;
              strobe.eipSeq    = 1'b1;
            end
            OP_POP: begin
              strobe.memRe  = 1'b1;
              strobe.eipSeq = 1'b1;
              phaseNext     = PH_POP2;
            end
            OP_CALL: begin
              strobe.memWe     = 1'b1;
              strobe.addrBelow = 1'b1;
              strobe.wdataRet  = 1'b1;
              strobe.espDown   = 1'b1;
              strobe.latchTgt  = 1'b1;
              phaseNext        = PH_CALL2;
            end
            OP_RET: begin
              strobe.memRe = 1'b1;
              phaseNext    = PH_RET2;
            end
            OP_JMP: strobe.eipTgtIn = 1'b1;
            OP_JZ: begin
              strobe.eipTgtIn = flagZero;
              strobe.eipSeq   = !flagZero;
            end
            OP_JS: begin
              strobe.eipTgtIn = flagSign;
              strobe.eipSeq   = !flagSign;
            end
            default: strobe = '0;
          endcase
        end
      end
      PH_CALL2: begin
        strobe.eipTgtHeld = 1'b1;
        phaseNext         = PH_IDLE;
      end
      PH_RET2: begin
        strobe.eipMem = 1'b1;
        strobe.espUp  = 1'b1;
        phaseNext     = PH_IDLE;
      end
      PH_POP2: begin
        strobe.capPop = 1'b1;
        strobe.espUp  = 1'b1;
        phaseNext     = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned LEN_W      = 4,
  parameter int unsigned WORD_BYTES = 4,
  parameter logic [XLEN-1:0] ESP_INIT = 'h100,
  parameter logic [XLEN-1:0] EIP_INIT = 'h1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  stkStrobe_t       strobe,
  input  logic [XLEN-1:0]  pushData,
  input  logic [XLEN-1:0]  target,
  input  logic [LEN_W-1:0] instLen,
  input  logic [XLEN-1:0]  memRdata,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  output logic             memWe,
  output logic             memRe,
  output logic [XLEN-1:0]  popData,
  output logic             popValid,
  output logic [XLEN-1:0]  eip,
  output logic [XLEN-1:0]  esp
);

  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

  logic [XLEN-1:0] espQ, eipQ, tgtQ;
  logic [XLEN-1:0] espBelow, espAbove, eipSeqVal;

  assign espBelow  = espQ - STEP;
  assign espAbove  = espQ + STEP;
  assign eipSeqVal = eipQ + XLEN'(instLen);

  assign memAddr  = strobe.addrBelow ? espBelow : espQ;
  assign memWdata = strobe.wdataRet ? eipSeqVal : pushData;
  assign memWe    = strobe.memWe;
  assign memRe    = strobe.memRe;
  assign eip      = eipQ;
  assign esp      = espQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      espQ     <= ESP_INIT;
      eipQ     <= EIP_INIT;
      tgtQ     <= '0;
      popData  <= '0;
      popValid <= 1'b0;
    end else begin
      if (strobe.latchTgt) tgtQ <= target;
      if (strobe.espDown)      espQ <= espBelow;
      else if (strobe.espUp)   espQ <= espAbove;
      if (strobe.eipTgtIn)        eipQ <= target;
      else if (strobe.eipTgtHeld) eipQ <= tgtQ;
      else if (strobe.eipMem)     eipQ <= memRdata;
      else if (strobe.eipSeq)     eipQ <= eipSeqVal;
      if (strobe.capPop) popData <= memRdata;
      popValid <= strobe.capPop;
    end
  end

endmodule

// File: rtl/stack_flow_unit.sv
module stack_flow_unit
  import stk_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned LEN_W      = 4,
  parameter int unsigned WORD_BYTES = 4,
  parameter logic [XLEN-1:0] ESP_INIT = 'h100,
  parameter logic [XLEN-1:0] EIP_INIT = 'h1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic [XLEN-1:0]  pushData,
  input  logic [XLEN-1:0]  target,
  input  logic [LEN_W-1:0] instLen,
  input  logic             flagZero,
  input  logic             flagSign,
  input  logic [XLEN-1:0]  memRdata,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  output logic             memWe,
  output logic             memRe,
  output logic [XLEN-1:0]  popData,
  output logic             popValid,
  output logic [XLEN-1:0]  eip,
  output logic [XLEN-1:0]  esp,
  output logic             busy
);

  stkStrobe_t strobe;

  stk_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .flagZero (flagZero),
    .flagSign (flagSign),
    .strobe   (strobe),
    .busy     (busy)
  );

  stk_datapath #(
    .XLEN       (XLEN),
    .LEN_W      (LEN_W),
    .WORD_BYTES (WORD_BYTES),
    .ESP_INIT   (ESP_INIT),
    .EIP_INIT   (EIP_INIT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pushData (pushData),
    .target   (target),
    .instLen  (instLen),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRe    (memRe),
    .popData  (popData),
    .popValid (popValid),
    .eip      (eip),
    .esp      (esp)
  );

endmodule

// File: rtl/stack_flow_unit_chk.sv
module stack_flow_unit_chk #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            opValid,
  input logic [2:0]      opCode,
  input logic [XLEN-1:0] target,
  input logic [XLEN-1:0] memAddr,
  input logic            memWe,
  input logic            memRe,
  input logic            popValid,
  input logic [XLEN-1:0] eip,
  input logic [XLEN-1:0] esp,
  input logic            busy
);

  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  p_esp_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(esp) |-> (esp == $past(esp) - STEP) || (esp == $past(esp) + STEP));

  p_write_below_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr == esp - STEP);

  p_read_top_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> memAddr == esp);

  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !memWe && !memRe);

  p_busy_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  p_call_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy && opCode == 3'd3) |=> busy);

  p_pop_after_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> $past(busy));

  p_jump_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy && opCode == 3'd5) |=> eip == $past(target));

endmodule

bind stack_flow_unit stack_flow_unit_chk #(
  .XLEN       (XLEN),
  .WORD_BYTES (WORD_BYTES)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .target   (target),
  .memAddr  (memAddr),
  .memWe    (memWe),
  .memRe    (memRe),
  .popValid (popValid),
  .eip      (eip),
  .esp      (esp),
  .busy     (busy)
);

// File: tb/stack_flow_unit_tb_top.sv
module stack_flow_unit_tb_top;

  localparam logic [31:0] ESP0 = 32'h0000_0100;
  localparam logic [31:0] EIP0 = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] pushData = '0, target = '0, memRdata = '0;
  logic [3:0]  instLen = '0;
  logic        flagZero = 1'b0, flagSign = 1'b0;
  logic [31:0] memAddr, memWdata, popData, eip, esp;
  logic        memWe, memRe, popValid, busy;

  int nChecks = 0;
  int nFail = 0;

  logic [31:0] benchMem [64];
  logic [31:0] mMem [64];
  logic [31:0] mEsp, mEip, mPop;

  always #5 clk = ~clk;

  stack_flow_unit #(.ESP_INIT(ESP0), .EIP_INIT(EIP0)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .pushData(pushData), .target(target), .instLen(instLen),
    .flagZero(flagZero), .flagSign(flagSign), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .popData(popData), .popValid(popValid), .eip(eip), .esp(esp), .busy(busy)
  );

  // single-cycle synchronous word memory
  always @(posedge clk) begin
    if (memWe) benchMem[memAddr[7:2]] <= memWdata;
    if (memRe) memRdata <= benchMem[memAddr[7:2]];
  end

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R8";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [5:0] idx(input logic [31:0] a);
    return a[7:2];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one operation at a negedge and check through to completion
  task automatic runOp(input logic [2:0] op, input logic [31:0] d,
                       input logic [31:0] t, input logic [3:0] len,
                       input logic fz, input logic fs, input bit probe);
    bit twoCyc = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
    logic expWe = 1'b0, expRe = 1'b0;
    logic [31:0] expAddr = '0, expWd = '0;
    string rq = reqOf(op);
    opValid = 1'b1; opCode = op; pushData = d; target = t; instLen = len;
    flagZero = fz; flagSign = fs;
    case (op)
      3'd1: begin expWe = 1; expAddr = mEsp - 4; expWd = d; end
      3'd3: begin expWe = 1; expAddr = mEsp - 4; expWd = mEip + 32'(len); end
      3'd2, 3'd4: begin expRe = 1; expAddr = mEsp; end
      default: ;
    endcase
    #1;
    chk(rq, "memWe", 32'(memWe), 32'(expWe));
    chk(rq, "memRe", 32'(memRe), 32'(expRe));
    if (expWe || expRe) chk(rq, "memAddr", memAddr, expAddr);
    if (expWe) chk(rq, "memWdata", memWdata, expWd);
    // reference model update
    case (op)
      3'd0: mEip = mEip + 32'(len);
      3'd1: begin mMem[idx(mEsp - 4)] = d; mEsp = mEsp - 4; mEip = mEip + 32'(len); end
      3'd2: begin mPop = mMem[idx(mEsp)]; mEsp = mEsp + 4; mEip = mEip + 32'(len); end
      3'd3: begin mMem[idx(mEsp - 4)] = mEip + 32'(len); mEsp = mEsp - 4; mEip = t; end
      3'd4: begin mEip = mMem[idx(mEsp)]; mEsp = mEsp + 4; end
      3'd5: mEip = t;
      3'd6: mEip = fz ? t : mEip + 32'(len);
      default: mEip = fs ? t : mEip + 32'(len);
    endcase
    @(posedge clk); @(negedge clk);
    if (twoCyc) begin
      chk("R9", "busy in second phase", 32'(busy), 32'd1);
      if (probe) begin
        opValid = 1'b1; opCode = 3'd1; pushData = 32'hDEAD_BEEF;
        #1;
        chk("R9", "strobe while busy", 32'(memWe | memRe), 32'd0);
      end else begin
        opValid = 1'b0;
      end
      @(posedge clk); @(negedge clk);
    end
    opValid = 1'b0;
    #1;
    chk(rq, "esp", esp, mEsp);
    chk(rq, "eip", eip, mEip);
    chk(rq, "busy after", 32'(busy), 32'd0);
    chk(rq, "popValid", 32'(popValid), 32'(op == 3'd2));
    if (op == 3'd2) chk("R3", "popData", popData, mPop);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      benchMem[i] = '0;
      mMem[i] = '0;
    end
    mEsp = ESP0; mEip = EIP0; mPop = '0;
    void'($urandom(32'd4242));
    // reset with an operation offered: enables must stay low (R1)
    opValid = 1'b1; opCode = 3'd1;
    repeat (3) @(negedge clk);
    chk("R1", "esp reset", esp, ESP0);
    chk("R1", "eip reset", eip, EIP0);
    chk("R1", "memWe reset", 32'(memWe), 32'd0);
    chk("R1", "memRe reset", 32'(memRe), 32'd0);
    chk("R1", "busy reset", 32'(busy), 32'd0);
    opValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "esp after release", esp, ESP0);
    chk("R1", "popValid after release", 32'(popValid), 32'd0);

    // directed corner cases
    runOp(3'd1, 32'h1111_0001, 32'h0, 4'd2, 0, 0, 0);       // push
    runOp(3'd1, 32'h2222_0002, 32'h0, 4'd3, 0, 0, 0);       // push
    runOp(3'd2, 32'h0, 32'h0, 4'd1, 0, 0, 0);               // pop -> 2222_0002
    runOp(3'd3, 32'h0, 32'h0000_4000, 4'd5, 0, 0, 1);       // call, probed
    runOp(3'd3, 32'h0, 32'h0000_5000, 4'd5, 0, 0, 0);       // nested call
    runOp(3'd4, 32'h0, 32'h0, 4'd1, 0, 0, 1);               // return, probed
    runOp(3'd4, 32'h0, 32'h0, 4'd1, 0, 0, 0);               // return
    runOp(3'd2, 32'h0, 32'h0, 4'd1, 0, 0, 1);               // pop, probed
    runOp(3'd5, 32'h0, 32'h0000_7000, 4'd2, 1, 1, 0);       // jump
    runOp(3'd6, 32'h0, 32'h0000_7100, 4'd2, 1, 0, 0);       // jz taken
    runOp(3'd6, 32'h0, 32'h0000_7200, 4'd2, 0, 1, 0);       // jz not taken
    runOp(3'd7, 32'h0, 32'h0000_7300, 4'd4, 0, 1, 0);       // js taken
    runOp(3'd7, 32'h0, 32'h0000_7400, 4'd4, 1, 0, 0);       // js not taken
    runOp(3'd0, 32'h0, 32'hFFFF_FFFF, 4'd15, 1, 1, 0);      // advance, max length

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      runOp(3'($urandom_range(0, 7)), $urandom(), $urandom() & 32'hFFFF_FFFC,
            4'($urandom_range(1, 15)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule